// File: doc/BRIEF.md
# Gate-Triggered Retriggerable Strobe Timer

This block is a one-shot delay timer. A delay value N is handed to it on a small valid/ready write port and kept until the next write. Writing the value does not start the timer. A timing run starts when the gate input, sampled on the clock, goes from low to high. The clock edge that sees that rise loads N into a down counter. That edge does not decrement. Each later edge decrements by one. When the counter reaches zero, the active-low output `strobe_n` goes low for exactly one clock and then returns high.

The timer can be retriggered. Every new rise of the gate reloads the stored value, so the strobe always comes N+1 clock edges after the most recent trigger. A value written while a run is in progress is held aside and used only at the next trigger. The gate level itself never drives the output. The write port never applies back-pressure: `cnt_ready` is high whenever reset is released, and every cycle with `cnt_valid` high stores `cnt_data`.

Top module: `gate_strobe_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `strobe_n` is 1 and no run is in progress.
- R2: A gate rise seen before any value has been written is ignored, and `strobe_n` stays 1.
- R3: Edge 0 is the clock edge that samples the gate at 1 while the sampled value one edge earlier was 0. If a value N (0..2^CNT_W-1) has been stored before edge 0, `strobe_n` is 0 in the clock period that follows edge N, which is the (N+1)th edge counting edge 0. Before that period `strobe_n` is 1.
- R4: The strobe lasts exactly one clock. Afterwards `strobe_n` stays 1 until a later trigger.
- R5: A trigger during a run reloads the stored value. The strobe then follows N+1 edges after the latest trigger, and the earlier run produces no strobe.
- R6: A value written during a run does not change that run. A value written on the same edge as a trigger is not used by that trigger. The value is first used by the next trigger after it was stored.
- R7: Holding the gate high, or letting it fall, has no effect on `strobe_n`. Only a 0-to-1 change between two consecutive sampled gate values starts a run.
- R8: A trigger on the edge that ends a strobe still lets that strobe last its full clock, and it reloads the counter so that a new strobe follows N+1 edges later.
- R9: `cnt_ready` is 1 whenever reset is released, so every write is accepted.
- R10: A gate that is already high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_valid | input | 1 | Write strobe for the delay value |
| cnt_ready | output | 1 | Write port can accept; never deasserted outside reset |
| cnt_data | input | CNT_W | Delay value N |
| gate | input | 1 | Trigger input, synchronous to clk |
| strobe_n | output | 1 | Active-low one-clock strobe |

## Verification
Several properties are checked on every cycle by the assertions. They check that the timer is silent until a value has been stored. They check that a strobe not followed by a trigger is exactly one clock long. They check that a trigger with a non-zero value never strobes on the next cycle, that every falling edge of `strobe_n` comes from a run or a trigger, and that a write during a run leaves the count going down by one. The exact delay from a trigger to its strobe can only be shown by the bench's scenarios. The same holds for retriggering, the point at which a new value takes effect, and the trigger that lands on a strobe edge. The bench sweeps every value of a 4-bit counter and scripts the gate and write timing around each of these cases.

// File: rtl/gate_strobe_timer_pkg.sv
package gate_strobe_timer_pkg;
  localparam int DEF_CNT_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_STROBE = 2'd2
  } run_state_e;

  function automatic logic is_rise(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/gtrig_edge.sv
module gtrig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  import gate_strobe_timer_pkg::*;

  logic gate_q;

  // Reset to 1 so a gate held high through reset is not a rise.
  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= gate;
  end

  assign rise = rst_n & is_rise(gate, gate_q);
endmodule

// File: rtl/gtrig_hold.sv
module gtrig_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] init_q,
  output logic             armed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0;
      armed  <= 1'b0;
    end else if (wr_en) begin
      init_q <= wr_data;
      armed  <= 1'b1;
    end
  end
endmodule

// File: rtl/gtrig_down.sv
module gtrig_down #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             at_zero
);
  import gate_strobe_timer_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  run_state_e st;

  assign running = (st != ST_IDLE);
  assign at_zero = (st == ST_STROBE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
      st  <= (load_val == '0) ? ST_STROBE : ST_COUNT;
    end else begin
      unique case (st)
        ST_COUNT: begin
          cnt <= cnt - ONE;
          if (cnt == ONE) st <= ST_STROBE;
        end
        ST_STROBE: st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gate_strobe_timer.sv
module gate_strobe_timer #(
  parameter int CNT_W = gate_strobe_timer_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_valid,
  output logic             cnt_ready,
  input  logic [CNT_W-1:0] cnt_data,
  input  logic             gate,
  output logic             strobe_n
);
  logic             rise;
  logic             armed;
  logic             trig;
  logic             running;
  logic             at_zero;
  logic [CNT_W-1:0] init_q;
  logic [CNT_W-1:0] cnt;

  assign cnt_ready = rst_n;

  gtrig_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .gate  (gate),
    .rise  (rise)
  );

  gtrig_hold #(.CNT_W(CNT_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cnt_valid & cnt_ready),
    .wr_data (cnt_data),
    .init_q  (init_q),
    .armed   (armed)
  );

  // Trigger uses the value stored before this edge.
  assign trig = rise & armed;

  gtrig_down #(.CNT_W(CNT_W)) u_down (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (trig),
    .load_val (init_q),
    .cnt      (cnt),
    .running  (running),
    .at_zero  (at_zero)
  );

  assign strobe_n = ~at_zero;
endmodule

// File: rtl/gate_strobe_timer_chk.sv
module gate_strobe_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_valid,
  input logic             strobe_n,
  input logic             armed,
  input logic             trig,
  input logic             running,
  input logic [CNT_W-1:0] init_q,
  input logic [CNT_W-1:0] cnt
);
  // R2
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> strobe_n);

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && !trig) |=> strobe_n);

  // R3
  load_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && init_q != '0) |=> strobe_n);

  // R7
  strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> ($past(running) || $past(trig)));

  // R6
  write_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_valid && !trig && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

bind gate_strobe_timer gate_strobe_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_valid (cnt_valid),
  .strobe_n  (strobe_n),
  .armed     (armed),
  .trig      (trig),
  .running   (running),
  .init_q    (init_q),
  .cnt       (cnt)
);

// File: tb/gate_strobe_timer_bench.sv
`timescale 1ns/1ps
module gate_strobe_timer_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_valid = 1'b0;
  logic         cnt_ready;
  logic [W-1:0] cnt_data = '0;
  logic         gate = 1'b0;
  logic         strobe_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gate_strobe_timer #(.CNT_W(W)) u_gate_strobe_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_valid (cnt_valid),
    .cnt_ready (cnt_ready),
    .cnt_data  (cnt_data),
    .gate      (gate),
    .strobe_n  (strobe_n)
  );

  task automatic check(input logic act, input logic exp, input string tag, input int idx);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at step %0d: actual=%b expected=%b", tag, idx, act, exp);
    end
  endtask

  task automatic do_reset(input logic g);
    rst_n = 1'b0;
    gate = g;
    cnt_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Store a value; returns on the negedge after the write edge.
  task automatic write_cnt(input logic [W-1:0] v);
    @(negedge clk);
    check(cnt_ready, 1'b1, "R9", 0);
    cnt_valid = 1'b1;
    cnt_data = v;
    @(negedge clk);
    cnt_valid = 1'b0;
  endtask

  // Sample strobe_n on negedges 1..len after the caller's drive at negedge 0.
  task automatic window(input int len, input int low_a, input int low_b,
                        input int gfall, input int grise, input int wr_at,
                        input logic [W-1:0] wr_val, input string tag);
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      check(strobe_n, (i == low_a || i == low_b) ? 1'b0 : 1'b1, tag, i);
      if (i == gfall) gate = 1'b0;
      if (i == grise) gate = 1'b1;
      cnt_valid = (i == wr_at);
      cnt_data = wr_val;
    end
    cnt_valid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    // R1 / R9: reset state
    do_reset(1'b0);
    #1;
    check(strobe_n, 1'b1, "R1", 0);
    check(cnt_ready, 1'b1, "R9", 0);

    // R2: rise before any write
    @(negedge clk);
    gate = 1'b1;
    window(20, 0, 0, 0, 0, 0, '0, "R2");
    gate = 1'b0;

    // R10: gate high across reset release, value written while held high
    do_reset(1'b1);
    write_cnt(4'd2);
    window(10, 0, 0, 0, 0, 0, '0, "R10");
    gate = 1'b0;
    @(negedge clk);

    // R3 / R4 / R7: every value of the counter
    for (int n = 0; n < 16; n++) begin
      write_cnt(W'(n));
      gate = 1'b1;
      window(20, n + 1, 0, (n % 2 == 1) ? 1 : 0, 0, 0, '0,
             (n % 2 == 1) ? "R3/R7" : "R3/R4");
      gate = 1'b0;
      @(negedge clk);
    end

    // R5: retrigger during a run
    write_cnt(4'd6);
    gate = 1'b1;
    window(20, 11, 0, 3, 4, 0, '0, "R5");
    gate = 1'b0;
    @(negedge clk);

    // R6: write during a run, used by the next trigger
    write_cnt(4'd5);
    gate = 1'b1;
    window(20, 6, 12, 8, 9, 2, 4'd2, "R6");
    gate = 1'b0;
    @(negedge clk);

    // R8: trigger on the edge that ends the strobe
    write_cnt(4'd3);
    gate = 1'b1;
    window(12, 4, 8, 2, 4, 0, '0, "R8");
    gate = 1'b0;
    @(negedge clk);

    // R6: write on the same edge as a trigger uses the older value
    write_cnt(4'd4);
    cnt_valid = 1'b1;
    cnt_data = 4'd9;
    gate = 1'b1;
    window(22, 5, 18, 7, 8, 0, '0, "R6 same-edge");
    gate = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule